// File: doc/BRIEF.md
# CAN Transmit Bit Monitor

This block sits next to a CAN transmitter. It compares the level the node means to drive with the level it reads back from the bus at each sample point. Logic 1 is recessive and logic 0 is dominant. A dominant level from any node wins on the wire. What a mismatch means depends on which part of the frame is on the bus:

- In the identifier (arbitration) field, reading dominant after sending recessive means a higher-priority frame is on the bus. The node backs off quietly and listens for the rest of the frame.
- In the control, data and CRC fields, any difference aborts the frame. The node then drives an error flag of six dominant bits.
- In the acknowledge slot, the transmitter leaves the bus recessive and expects another node to pull it dominant. If the slot reads back recessive, that is an acknowledge error, which also leads to the error flag.

The frame formatter drives the inputs. It supplies the intended bit, the sampled bus bit, a single-cycle strobe at each sample point, a two-bit field code and a one-cycle frame-start pulse. The block returns the level to put on the transceiver's transmit pin and three sticky outcome flags. The formatter uses these flags to decide whether to retry the frame. Stuffing, CRC and error counting are handled elsewhere.

Top module: `can_tx_bitmon`

## Requirements
- R1: After reset, and in the cycle after a frame_start pulse, arb_lost, bit_err and ack_err are all 0. In that cycle tx_drive equals tx_bit, provided phase is not the acknowledge code.
- R2: While the node is transmitting and no outcome flag is set, tx_drive equals tx_bit in every field except the acknowledge slot. A strobe at which tx_bit and rx_bit agree sets no flag.
- R3: A strobe with phase 2'b01 (arbitration), tx_bit = 1 and rx_bit = 0 sets arb_lost in the next cycle and does not set bit_err.
- R4: Once arb_lost is set, tx_drive stays 1 (recessive) and every later strobe is ignored until frame_start. No bit_err or ack_err can be raised in that time.
- R5: A strobe with phase 2'b10 (control/data/CRC) where tx_bit differs from rx_bit, in either direction, sets bit_err in the next cycle. A strobe with phase 2'b01 where tx_bit = 0 and rx_bit = 1 also sets bit_err.
- R6: When bit_err or ack_err rises, tx_drive goes 0 (dominant) in the same cycle and stays 0 for exactly six further strobes. From the sixth strobe onwards tx_drive is 1 until frame_start.
- R7: With phase 2'b11 (acknowledge slot), tx_drive is 1 whatever tx_bit is. A strobe there with rx_bit = 1 sets ack_err. A strobe there with rx_bit = 0 sets no flag.
- R8: A strobe with phase 2'b00 (unchecked field) sets no flag, even when tx_bit and rx_bit differ.
- R9: Outcome flags hold until frame_start. A frame_start in the same cycle as a mismatching strobe clears the flags and leaves them clear.
- R10: Without samp_stb, a difference between tx_bit and rx_bit sets no flag.
- R11: At most one of arb_lost, bit_err and ack_err is ever set. After the first outcome, further mismatches raise nothing new.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse at the start of a frame; clears the outcome and rearms the monitor |
| samp_stb | input | 1 | One-cycle strobe at the bit's sample point |
| phase | input | 2 | Field code: 00 unchecked, 01 arbitration, 10 control/data/CRC, 11 acknowledge slot |
| tx_bit | input | 1 | Bit the formatter intends to send (1 = recessive) |
| rx_bit | input | 1 | Bus level sampled at the sample point |
| tx_drive | output | 1 | Level for the transceiver transmit pin |
| arb_lost | output | 1 | Sticky: arbitration lost, node is now a receiver |
| bit_err | output | 1 | Sticky: readback mismatch outside arbitration backoff |
| ack_err | output | 1 | Sticky: acknowledge slot read back recessive |

## Verification
The same intended/readback pairs are applied under each field code. This shows that one mismatch gives a silent backoff, an error flag, an acknowledge error or nothing, depending on the field. Within arbitration, both mismatch directions are tried, which separates a lost arbitration from a bit error. In the acknowledge slot, both readback levels are tried, which separates a good acknowledge from a missing one. The error flag is counted across strobes mixed with idle cycles, so a flag that is one bit short or one bit long shows up. A frame start that coincides with a mismatch checks that the clear takes priority over the strobe.

// File: rtl/can_bitmon_pkg.sv
// Shared types for the CAN transmit bit monitor.
// Assumes the field code is supplied by the frame formatter, aligned to the strobe.
package can_bitmon_pkg;

    // Field code carried on the phase input
    typedef enum logic [1:0] {
        PH_IDLE  = 2'b00,
        PH_ARB   = 2'b01,
        PH_CHECK = 2'b10,
        PH_ACK   = 2'b11
    } phase_e;

    // Monitor state within one frame
    typedef enum logic [1:0] {
        ST_SEND   = 2'b00,
        ST_LISTEN = 2'b01,
        ST_FLAG   = 2'b10,
        ST_PARKED = 2'b11
    } mon_state_e;

    // Outcome of judging one sample point
    typedef struct packed {
        logic lose;
        logic bit_mis;
        logic ack_miss;
    } verdict_t;

endpackage

// File: rtl/bitmon_judge.sv
// Classifies one sample point by field.
// Purely combinational; every verdict is gated by the strobe and by 'sending',
// so nothing is judged once the node has stopped transmitting.
module bitmon_judge
    import can_bitmon_pkg::*;
(
    input  logic       sending,
    input  logic       stb,
    input  logic [1:0] phase,
    input  logic       tx_bit,
    input  logic       rx_bit,
    output verdict_t   verdict
);

    logic live;

    // Decide what a readback difference means in the current field
    always_comb begin
        live             = sending && stb;
        verdict.lose     = live && (phase == PH_ARB)   && tx_bit && !rx_bit;
        verdict.bit_mis  = live && (((phase == PH_CHECK) && (tx_bit != rx_bit)) ||
                                    ((phase == PH_ARB) && !tx_bit && rx_bit));
        verdict.ack_miss = live && (phase == PH_ACK)   && rx_bit;
    end

endmodule

// File: rtl/bitmon_errflag.sv
// Error-flag timer: once started, stays active for FLAG_BITS sample strobes.
// 'last' marks the strobe that ends the flag. Assumes start and clr are
// single-cycle pulses; the strobe that caused the start is not counted.
module bitmon_errflag #(
    parameter int FLAG_BITS = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic start,
    input  logic stb,
    output logic active,
    output logic last
);

    localparam int CNT_W = (FLAG_BITS > 2) ? $clog2(FLAG_BITS) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FLAG_BITS - 1);

    logic [CNT_W-1:0] cnt;

    // Count strobes while the flag is on the bus
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active && stb) begin
            if (cnt == LAST_IDX) begin
                active <= 1'b0;
            end
            cnt <= cnt + 1'b1;
        end
    end

    // Flag the final strobe of the error flag
    always_comb begin
        last = active && stb && (cnt == LAST_IDX);
    end

endmodule

// File: rtl/bitmon_ctrl.sv
// Per-frame controller: tracks whether the node still sends, has backed off,
// is driving an error flag or has parked recessive. It also keeps the sticky
// outcome flags. frame_start has priority over every verdict.
module bitmon_ctrl
    import can_bitmon_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  verdict_t   verdict,
    input  logic       flag_last,
    output mon_state_e state,
    output logic       flag_start,
    output logic       arb_lost,
    output logic       bit_err,
    output logic       ack_err
);

    // Request the error flag on the first fault of a frame
    always_comb begin
        flag_start = (state == ST_SEND) && !frame_start &&
                     (verdict.bit_mis || verdict.ack_miss);
    end

    // Advance the frame state
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start) begin
            state <= ST_SEND;
        end else begin
            case (state)
                ST_SEND: begin
                    if (verdict.lose) begin
                        state <= ST_LISTEN;
                    end else if (verdict.bit_mis || verdict.ack_miss) begin
                        state <= ST_FLAG;
                    end
                end
                ST_FLAG: begin
                    if (flag_last) begin
                        state <= ST_PARKED;
                    end
                end
                default: state <= state;
            endcase
        end
    end

    // Latch the outcome flags until the next frame
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start) begin
            arb_lost <= 1'b0;
            bit_err  <= 1'b0;
            ack_err  <= 1'b0;
        end else if (state == ST_SEND) begin
            arb_lost <= verdict.lose;
            bit_err  <= verdict.bit_mis;
            ack_err  <= verdict.ack_miss;
        end
    end

endmodule

// File: rtl/can_tx_bitmon.sv
// CAN transmit bit monitor, top level.
// Compares the intended bit with the sampled bus bit at each strobe and reacts
// by field: backoff in arbitration, error flag elsewhere, and an acknowledge
// check in the acknowledge slot. Assumes one strobe per bit time.
module can_tx_bitmon
    import can_bitmon_pkg::*;
#(
    parameter int FLAG_BITS = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic       samp_stb,
    input  logic [1:0] phase,
    input  logic       tx_bit,
    input  logic       rx_bit,
    output logic       tx_drive,
    output logic       arb_lost,
    output logic       bit_err,
    output logic       ack_err
);

    mon_state_e state;
    verdict_t   verdict;
    logic       sending;
    logic       flag_start;
    logic       flag_active;
    logic       flag_last;

    // Judging is enabled only while the node still owns its frame
    always_comb begin
        sending = (state == ST_SEND);
    end

    bitmon_judge u_judge (
        .sending (sending),
        .stb     (samp_stb),
        .phase   (phase),
        .tx_bit  (tx_bit),
        .rx_bit  (rx_bit),
        .verdict (verdict)
    );

    bitmon_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .verdict     (verdict),
        .flag_last   (flag_last),
        .state       (state),
        .flag_start  (flag_start),
        .arb_lost    (arb_lost),
        .bit_err     (bit_err),
        .ack_err     (ack_err)
    );

    bitmon_errflag #(
        .FLAG_BITS (FLAG_BITS)
    ) u_errflag (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (frame_start),
        .start  (flag_start),
        .stb    (samp_stb),
        .active (flag_active),
        .last   (flag_last)
    );

    // Choose the transmit pin level from the frame state and field
    always_comb begin
        case (state)
            ST_SEND:  tx_drive = (phase == PH_ACK) ? 1'b1 : tx_bit;
            ST_FLAG:  tx_drive = !flag_active;
            default:  tx_drive = 1'b1;
        endcase
    end

endmodule

// File: rtl/can_tx_bitmon_chk.sv
// Property checker for can_tx_bitmon, bound to every instance.
// It sees only the top-level ports. The error-flag window is measured with
// a local strobe counter.
module can_tx_bitmon_chk #(
    parameter int FLAG_BITS = 6
) (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_start,
    input logic       samp_stb,
    input logic [1:0] phase,
    input logic       tx_bit,
    input logic       rx_bit,
    input logic       tx_drive,
    input logic       arb_lost,
    input logic       bit_err,
    input logic       ack_err
);

    localparam int FW = $clog2(FLAG_BITS + 1);
    localparam logic [FW-1:0] FB = FW'(FLAG_BITS);

    logic [FW-1:0] fcnt;
    logic          any_out;

    // Any outcome already recorded for this frame
    always_comb begin
        any_out = arb_lost || bit_err || ack_err;
    end

    // Count strobes seen while an error outcome is held, saturating at the flag length
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start) begin
            fcnt <= '0;
        end else if ((bit_err || ack_err) && samp_stb && (fcnt < FB)) begin
            fcnt <= fcnt + 1'b1;
        end
    end

    p_arb_lose_r3: assert property (@(posedge clk) disable iff (!rst_n)
        samp_stb && phase == 2'b01 && tx_drive && !rx_bit && !frame_start && !any_out
        |=> arb_lost && !bit_err);

    p_listen_recessive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |-> tx_drive);

    p_data_mismatch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        samp_stb && phase == 2'b10 && (tx_drive != rx_bit) && !frame_start && !any_out
        |=> bit_err);

    p_flag_dominant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_err || ack_err) && (fcnt < FB) |-> !tx_drive);

    p_flag_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fcnt == FB) |-> tx_drive);

    p_ack_missing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        samp_stb && phase == 2'b11 && rx_bit && !frame_start && !any_out
        |=> ack_err);

    p_ack_recessive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        phase == 2'b11 && !any_out |-> tx_drive);

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !any_out);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        any_out && !frame_start |=> any_out);

    p_no_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_stb && !any_out |=> !any_out);

    p_single_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arb_lost, bit_err, ack_err}));

endmodule

bind can_tx_bitmon can_tx_bitmon_chk #(
    .FLAG_BITS (FLAG_BITS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .samp_stb    (samp_stb),
    .phase       (phase),
    .tx_bit      (tx_bit),
    .rx_bit      (rx_bit),
    .tx_drive    (tx_drive),
    .arb_lost    (arb_lost),
    .bit_err     (bit_err),
    .ack_err     (ack_err)
);

// File: tb/can_tx_bitmon_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes the expected outputs of each cycle,
// and the monitor pops them and compares just after the following clock edge.
module can_tx_bitmon_bench;

    localparam logic [1:0] P_IDLE = 2'b00;
    localparam logic [1:0] P_ARB  = 2'b01;
    localparam logic [1:0] P_CHK  = 2'b10;
    localparam logic [1:0] P_ACK  = 2'b11;

    typedef struct {
        logic [3:0] exp;   // {tx_drive, arb_lost, bit_err, ack_err}
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic       samp_stb = 1'b0;
    logic [1:0] phase = P_IDLE;
    logic       tx_bit = 1'b1;
    logic       rx_bit = 1'b1;
    logic       tx_drive, arb_lost, bit_err, ack_err;

    item_t q[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;

    always #4 clk = ~clk;

    can_tx_bitmon u_can_tx_bitmon (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .samp_stb    (samp_stb),
        .phase       (phase),
        .tx_bit      (tx_bit),
        .rx_bit      (rx_bit),
        .tx_drive    (tx_drive),
        .arb_lost    (arb_lost),
        .bit_err     (bit_err),
        .ack_err     (ack_err)
    );

    // Drive one cycle of inputs and queue the outputs expected after its edge
    task automatic step(input logic [1:0] ph, input logic tb, input logic rb,
                        input logic st, input logic fs, input logic [3:0] e,
                        input string tag);
        item_t it;
        @(negedge clk);
        phase = ph; tx_bit = tb; rx_bit = rb; samp_stb = st; frame_start = fs;
        it.exp = e;
        it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: compare after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                item_t it;
                logic [3:0] act;
                it  = q.pop_front();
                act = {tx_drive, arb_lost, bit_err, ack_err};
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s: {drv,lost,berr,aerr} actual=%b expected=%b",
                             it.tag, act, it.exp);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Driver: scenarios
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        step(P_IDLE, 1, 1, 0, 0, 4'b1000, "R1 reset");
        // R1 frame start, R2 matching bits
        step(P_ARB, 0, 0, 0, 1, 4'b0000, "R1 frame start");
        step(P_ARB, 0, 0, 1, 0, 4'b0000, "R2 arb dominant match");
        step(P_ARB, 1, 1, 1, 0, 4'b1000, "R2 arb recessive match");
        step(P_CHK, 0, 0, 1, 0, 4'b0000, "R2 data match");
        step(P_IDLE, 0, 1, 1, 0, 4'b0000, "R8 unchecked field mismatch");
        step(P_CHK, 1, 0, 0, 0, 4'b1000, "R10 mismatch without strobe");
        // R3 lost arbitration then R4 silence
        step(P_ARB, 1, 0, 1, 0, 4'b1100, "R3 arbitration lost");
        step(P_CHK, 0, 1, 1, 0, 4'b1100, "R4 data mismatch ignored");
        step(P_ACK, 1, 1, 1, 0, 4'b1100, "R4 ack ignored");
        step(P_CHK, 0, 0, 0, 0, 4'b1100, "R4 tx held recessive");
        // R9 clear
        step(P_CHK, 0, 0, 0, 1, 4'b0000, "R9 clear after lost");
        // R5 data error, R6 six-bit flag
        step(P_CHK, 0, 1, 1, 0, 4'b0010, "R5 data dominant read recessive");
        for (int i = 1; i <= 5; i++) begin
            step(P_CHK, 1, 0, 1, 0, 4'b0010, "R6 flag dominant");
            step(P_CHK, 1, 1, 0, 0, 4'b0010, "R6 flag between strobes");
        end
        step(P_CHK, 0, 0, 1, 0, 4'b1010, "R6 flag released after six");
        step(P_CHK, 0, 1, 1, 0, 4'b1010, "R11 no second outcome");
        step(P_ACK, 0, 1, 1, 0, 4'b1010, "R11 no ack after bit error");
        // R9 clear beats simultaneous mismatch
        step(P_CHK, 0, 1, 1, 1, 4'b0000, "R9 clear priority");
        step(P_CHK, 1, 0, 1, 0, 4'b0010, "R5 data recessive read dominant");
        step(P_ARB, 0, 1, 1, 1, 4'b0000, "R9 clear again");
        step(P_ARB, 0, 1, 1, 0, 4'b0010, "R5 arb dominant read recessive");
        // R7 acknowledge slot
        step(P_ACK, 0, 0, 0, 1, 4'b1000, "R7 ack forced recessive");
        step(P_ACK, 0, 0, 1, 0, 4'b1000, "R7 ack received");
        step(P_ACK, 1, 1, 0, 1, 4'b1000, "R1 clear in ack slot");
        step(P_ACK, 1, 1, 1, 0, 4'b0001, "R7 ack missing");
        for (int i = 1; i <= 5; i++) begin
            step(P_IDLE, 1, 0, 1, 0, 4'b0001, "R6 ack flag dominant");
        end
        step(P_IDLE, 0, 0, 1, 0, 4'b1001, "R6 ack flag released");
        step(P_IDLE, 0, 0, 0, 0, 4'b1001, "R9 ack error held");
        // drain
        wait (q.size() == 0);
        @(posedge clk);
        #3;
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule